// File: doc/BRIEF.md
# Output Aggregation Stage of a Feed-Forward Network

This block closes a small fixed-point feed-forward network. A bank of hidden neurons each produces one partial product per output-side node and raises a done flag. The block waits until every hidden neuron is done. It then reduces the products into one sum per output-side node. The reduction runs over four sequential stages, and each stage folds one group of neurons into a running sum register. The group sizes do not have to be equal. In the last stage each finished sum is clamped at zero, so a negative sum becomes zero.

A single shared multiplier then scales each clamped sum by its own fixed weight, one product per cycle. The products are accumulated onto a fixed bias. Both the weights and the bias are parameters of the module. The scalar result is held with a valid flag until the host asks for the next evaluation.

The host requests the next evaluation with a rising edge on its ready input. That edge clears the result flag, returns the stage to waiting, and sends a one-cycle restart pulse to the hidden neurons. All arithmetic is two's-complement in 27 bits: 3 integer bits and 23 fraction bits.

Top module: `agg_out_layer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `valid_o`, `restart_o` and `result_o` are all zero.
- R2: An evaluation starts only when every bit of `done_i` is high at a clock edge. While any bit is low the block stays idle and `valid_o` stays low.
- R3: The held result equals B + Σk W[k]·relu(S[k]) with S[k] = Σn P[n][k]. P[n][k] is the 27-bit field `prod_i[(n*N_MID+k)*27 +: 27]`. Every sum wraps modulo 2^27, and each product is the full signed product shifted right arithmetically by 23 and truncated to 27 bits. The bench uses W = {1.0, -2.0, 3.0, 0.5} for nodes 0..3 and B = 0.25.
- R4: Clamping applies to each complete per-node sum only, never to a partial group sum. A node whose first group is negative but whose total is positive contributes that positive total.
- R5: If all done flags are first sampled high at edge e, then `valid_o` rises at edge e+4+N_MID. With N_MID = 4 that is 9 rising edges after the flags are applied.
- R6: Once `valid_o` is high, it and `result_o` hold steady until a rising edge of `ready_i`. A `ready_i` held high past its first cycle causes no further clear.
- R7: At the edge where `ready_i` is first seen high after being low, `valid_o` clears. `restart_o` is high for exactly the following cycle.
- R8: A rising edge of `ready_i` during an evaluation abandons it: no `valid_o` appears for that evaluation, and the block returns to waiting for the done flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prod_i | input | N_HID*N_MID*27 | Partial products, one 27-bit field per neuron and node |
| done_i | input | N_HID | Per-neuron done flags |
| ready_i | input | 1 | Host ready; its rising edge requests a new evaluation |
| result_o | output | 27 | Scalar result, Q3.23 |
| valid_o | output | 1 | Result is valid |
| restart_o | output | 1 | One-cycle pulse that returns the hidden neurons to compute |

## Verification
A wrong stage counter or group offset changes the sum that reaches the multiplier. It shows up as a wrong `result_o` in the same cycle that `valid_o` rises. Clamping a partial sum instead of the full sum shows up only with inputs that change sign across groups, so the bench builds that case on purpose. A miscounted stage or multiply sequence moves the rising edge of `valid_o` away from edge e+4+N_MID. The per-clock reference catches that at the first clock where the two disagree. A broken ready edge detector shows up as a `valid_o` that does not clear or a `restart_o` of the wrong length, one cycle after the edge.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_ADD, ST_MAC, ST_DONE} state_e;
endpackage

// File: rtl/agg_group_sum.sv
module agg_group_sum #(
  parameter int DW    = 27,
  parameter int N_MID = 4,
  parameter int CNT   = 25
) (
  input  logic [CNT*N_MID*DW-1:0] prod_i,
  output logic [N_MID*DW-1:0]     sum_o
);
  logic [DW-1:0] acc;

  always_comb begin
    sum_o = '0;
    acc   = '0;
    for (int k = 0; k < N_MID; k++) begin
      acc = '0;
      for (int n = 0; n < CNT; n++) acc = acc + prod_i[(n*N_MID+k)*DW +: DW];
      sum_o[k*DW +: DW] = acc;
    end
  end
endmodule

// File: rtl/agg_mac.sv
module agg_mac #(
  parameter int DW   = 27,
  parameter int FRAC = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] bias_i,
  input  logic          en_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] acc_o
);
  logic signed [2*DW-1:0] full_p;
  logic [DW-1:0]          term;
  logic                   unused_bits;

  assign full_p      = $signed(a_i) * $signed(b_i);
  assign term        = full_p[FRAC +: DW];
  assign unused_bits = ^{full_p[FRAC-1:0], full_p[2*DW-1:FRAC+DW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= bias_i;
    else if (en_i)   acc_o <= acc_o + term;
  end
endmodule

// File: rtl/agg_out_layer.sv
module agg_out_layer
  import agg_pkg::*;
#(
  parameter int DW    = 27,
  parameter int FRAC  = 23,
  parameter int N_HID = 75,
  parameter int N_MID = 4,
  parameter int G0    = 25,
  parameter int G1    = 25,
  parameter int G2    = 15,
  parameter int G3    = 10,
  parameter logic [N_MID*DW-1:0] W_OUT = {4{27'h0800000}},
  parameter logic [DW-1:0]       B_OUT = 27'h0400000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_HID*N_MID*DW-1:0] prod_i,
  input  logic [N_HID-1:0]          done_i,
  input  logic                      ready_i,
  output logic [DW-1:0]             result_o,
  output logic                      valid_o,
  output logic                      restart_o
);
  localparam int IW = (N_MID > 1) ? $clog2(N_MID) : 1;

  state_e         state_q;
  logic [1:0]     stg_q;
  logic [IW-1:0]  idx_q;
  logic [DW-1:0]  sum_q   [N_MID];
  logic [DW-1:0]  sum_nxt [N_MID];
  logic           ready_q;
  logic           rise;
  logic           all_done;
  logic [N_MID*DW-1:0] grp_sum [4];
  logic [N_MID*DW-1:0] grp_sel;
  logic [DW-1:0]  mac_a;
  logic [DW-1:0]  mac_b;
  logic           mac_load;
  logic           mac_en;

  assign rise     = ready_i & ~ready_q;
  assign all_done = &done_i;

  for (genvar g = 0; g < 4; g++) begin : g_grp
    localparam int CNT  = (g == 0) ? G0 : (g == 1) ? G1 : (g == 2) ? G2 : G3;
    localparam int BASE = ((g > 0) ? G0 : 0) + ((g > 1) ? G1 : 0) + ((g > 2) ? G2 : 0);
    agg_group_sum #(.DW(DW), .N_MID(N_MID), .CNT(CNT)) i_grp (
      .prod_i (prod_i[BASE*N_MID*DW +: CNT*N_MID*DW]),
      .sum_o  (grp_sum[g])
    );
  end

  assign grp_sel = grp_sum[stg_q];

  // clamp only on the final stage, once the whole sum is known
  always_comb begin
    for (int k = 0; k < N_MID; k++) begin
      sum_nxt[k] = sum_q[k] + grp_sel[k*DW +: DW];
      if (stg_q == 2'd3 && sum_nxt[k][DW-1]) sum_nxt[k] = '0;
    end
  end

  assign mac_a    = sum_q[idx_q];
  assign mac_b    = W_OUT[idx_q*DW +: DW];
  assign mac_load = (state_q == ST_WAIT) && all_done && !rise;
  assign mac_en   = (state_q == ST_MAC) && !rise;

  agg_mac #(.DW(DW), .FRAC(FRAC)) i_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mac_load),
    .bias_i (B_OUT),
    .en_i   (mac_en),
    .a_i    (mac_a),
    .b_i    (mac_b),
    .acc_o  (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT;
      stg_q     <= '0;
      idx_q     <= '0;
      ready_q   <= 1'b0;
      valid_o   <= 1'b0;
      restart_o <= 1'b0;
      for (int k = 0; k < N_MID; k++) sum_q[k] <= '0;
    end else begin
      ready_q   <= ready_i;
      restart_o <= rise;
      if (rise) begin
        state_q <= ST_WAIT;
        valid_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_WAIT: if (all_done) begin
            state_q <= ST_ADD;
            stg_q   <= '0;
            idx_q   <= '0;
            for (int k = 0; k < N_MID; k++) sum_q[k] <= '0;
          end
          ST_ADD: begin
            for (int k = 0; k < N_MID; k++) sum_q[k] <= sum_nxt[k];
            stg_q <= stg_q + 2'd1;
            if (stg_q == 2'd3) state_q <= ST_MAC;
          end
          ST_MAC: begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IW'(N_MID-1)) begin
              state_q <= ST_DONE;
              valid_o <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/agg_out_layer_chk.sv
module agg_out_layer_chk
  import agg_pkg::*;
#(
  parameter int DW    = 27,
  parameter int N_HID = 75,
  parameter int N_MID = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_HID-1:0] done_i,
  input logic             ready_i,
  input logic [DW-1:0]    result_o,
  input logic             valid_o,
  input logic             restart_o,
  input state_e           state_q,
  input logic [DW-1:0]    mac_a
);
  logic rdy_q;
  logic rise_c;
  int   lat_q;

  assign rise_c = ready_i & ~rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      lat_q <= 0;
    end else begin
      rdy_q <= ready_i;
      if (rise_c)                                 lat_q <= 0;
      else if (state_q == ST_WAIT && (&done_i))   lat_q <= 1;
      else if (lat_q != 0)                        lat_q <= lat_q + 1;
    end
  end

  p_idle_until_all_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !(&done_i)) |=> (state_q == ST_WAIT));

  p_clamped_operand_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAC) |-> !mac_a[DW-1]);

  p_valid_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (lat_q == N_MID + 5));

  p_result_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rise_c) |=> (valid_o && $stable(result_o)));

  p_clear_on_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_c |=> (!valid_o && restart_o));

  p_restart_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
endmodule

bind agg_out_layer agg_out_layer_chk #(.DW(DW), .N_HID(N_HID), .N_MID(N_MID)) i_chk (.*);

// File: tb/test_agg_out_layer.sv
`timescale 1ns/1ps
module test_agg_out_layer;
  localparam int DW    = 27;
  localparam int FRAC  = 23;
  localparam int N_HID = 75;
  localparam int N_MID = 4;
  // node3=0.5, node2=3.0, node1=-2.0, node0=1.0
  localparam logic [N_MID*DW-1:0] W_T = {27'h0400000, 27'h1800000, 27'h7000000, 27'h0800000};
  localparam logic [DW-1:0]       B_T = 27'h0200000;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_HID*N_MID*DW-1:0] prod;
  logic [N_HID-1:0] done;
  logic ready;
  logic [DW-1:0] result;
  logic valid, restart;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  agg_out_layer #(.DW(DW), .FRAC(FRAC), .N_HID(N_HID), .N_MID(N_MID),
                  .W_OUT(W_T), .B_OUT(B_T)) i_agg_out_layer (
    .clk_i(clk), .rst_ni(rst_n), .prod_i(prod), .done_i(done), .ready_i(ready),
    .result_o(result), .valid_o(valid), .restart_o(restart));

  function automatic longint wrap(longint x);
    longint m;
    m = x & ((64'sd1 <<< DW) - 1);
    if (m >= (64'sd1 <<< (DW-1))) m = m - (64'sd1 <<< DW);
    return m;
  endfunction

  function automatic longint pval(int p, int n, int k);
    case (p)
      0: return longint'(((n % 5) + 1) * 4096 * (k + 1));
      1: return (k == 1) ? -longint'(((n % 3) + 1) * 8192) : longint'(((n % 7) - 3) * 2048);
      2: begin
        if (k == 0) return (n < 25) ? -(64'sd1 <<< 18) : (64'sd1 <<< 18);
        if (k == 2) return (n >= 65) ? -(64'sd1 <<< 19) : (64'sd1 <<< 16);
        return longint'((n % 4) * 1024);
      end
      default: return longint'(((n % 9) - 2) * 3000 + k * 700);
    endcase
  endfunction

  task automatic load_pat(int p);
    for (int n = 0; n < N_HID; n++)
      for (int k = 0; k < N_MID; k++)
        prod[(n*N_MID+k)*DW +: DW] = DW'(pval(p, n, k));
  endtask

  function automatic longint model_result();
    longint acc, s, t;
    acc = wrap(longint'(B_T));
    for (int k = 0; k < N_MID; k++) begin
      s = 0;
      for (int n = 0; n < N_HID; n++) s = s + wrap(longint'(prod[(n*N_MID+k)*DW +: DW]));
      s = wrap(s);
      if (s < 0) s = 0;
      t = wrap((s * wrap(longint'(W_T[k*DW +: DW]))) >>> FRAC);
      acc = wrap(acc + t);
    end
    return acc;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle reference
  int     m_ph;
  int     m_cnt;
  bit     m_valid, m_restart, m_rdy;
  longint m_exp, m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_valid = 0; m_restart = 0; m_rdy = 0; m_exp = 0; m_res = 0;
    end else begin
      bit rise;
      rise = ready && !m_rdy;
      m_rdy = ready;
      m_restart = rise;
      if (rise) begin
        m_ph = 0; m_valid = 0;
      end else if (m_ph == 0) begin
        if (&done) begin m_ph = 1; m_cnt = 4 + N_MID; m_exp = model_result(); end
      end else if (m_ph == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin m_ph = 2; m_valid = 1; m_res = m_exp; end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(valid == m_valid, "R2 R5 R8 valid vs reference", valid, m_valid);
    chk(restart == m_restart, "R7 restart vs reference", restart, m_restart);
    if (m_valid) chk(wrap(longint'(result)) == m_res, "R3 result vs reference",
                     wrap(longint'(result)), m_res);
  end

  task automatic eval_and_check(string req, int exp_lat);
    int cnt;
    cnt = 0;
    done = '1;
    do begin @(negedge clk); cnt++; end while (!valid && cnt < 40);
    if (exp_lat > 0) chk(cnt == exp_lat, "R5 latency", cnt, exp_lat);
    chk(wrap(longint'(result)) == model_result(), req, wrap(longint'(result)), model_result());
  endtask

  task automatic pulse_ready();
    @(negedge clk); done = '0; ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint held;
    rst_n = 1'b0; ready = 1'b0; done = '0; prod = '0;
    repeat (3) @(negedge clk);
    chk(!valid && !restart && result == '0, "R1 in reset", {valid, restart}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !restart && result == '0, "R1 after release", {valid, restart}, 0);

    // R2: one neuron missing
    load_pat(0);
    done = {1'b0, {(N_HID-1){1'b1}}};
    repeat (20) @(negedge clk);
    chk(!valid, "R2 partial done stays idle", valid, 0);

    eval_and_check("R3 pattern 0", N_MID + 5);
    held = longint'(result);
    repeat (5) @(negedge clk);
    chk(valid && longint'(result) == held, "R6 result held", longint'(result), held);

    // R7 clear and restart, then ready left high
    @(negedge clk); done = '0; ready = 1'b1;
    @(negedge clk);
    chk(!valid && restart, "R7 clear with restart", {valid, restart}, 1);
    @(negedge clk);
    chk(!restart, "R7 restart one cycle", restart, 0);
    load_pat(3);
    eval_and_check("R3 pattern 3 with ready high", N_MID + 5);
    repeat (4) @(negedge clk);
    chk(valid, "R6 ready held high causes no clear", valid, 1);
    ready = 1'b0; done = '0;
    @(negedge clk);
    pulse_ready();
    chk(!valid, "R7 cleared after pulse", valid, 0);

    load_pat(1);
    eval_and_check("R3 pattern 1 negative node", N_MID + 5);
    pulse_ready();

    load_pat(2);
    eval_and_check("R4 clamp on full sum only", N_MID + 5);
    pulse_ready();

    // R8 abort mid evaluation
    load_pat(0);
    done = '1;
    repeat (3) @(negedge clk);
    done = '0; ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(!valid, "R8 aborted evaluation gives no valid", valid, 0);
    end
    eval_and_check("R8 R3 evaluation after abort", N_MID + 5);
    pulse_ready();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule